// File: doc/BRIEF.md
# High-Valency Prefix Adder

This block adds two integer words. Every carry comes from a parallel prefix network of group generate/propagate cells, and each cell merges up to `VALENCY` groups at once. A higher valency lowers the number of tree levels. The word is cut into blocks of `BLOCK` bits. Each block has its own local prefix sub-tree, and that sub-tree drives only the sum bits of its block. A second prefix tree over the block groups supplies the carry into each block. This split limits how many sum bits hang on any one carry node.

A mode pin selects one of two arithmetic modes:

- **Normal mode:** two's-complement addition with an external carry-in.
- **End-around-carry mode:** the carry-out of the word is fed back into every bit position. This produces ones'-complement sums. No second carry pass or carry-select path is needed, because the carry for bit i is formed from the low prefix group and the full-word group generate.

Operands enter through a valid/ready handshake and results leave through one. The handshake rules are:

- When `PIPE` is 1, a single output register holds the result. The register accepts a new operand pair in any cycle in which it is empty or its result is being taken. Back-pressure therefore reaches the input in the same cycle.
- When `PIPE` is 0, the block is purely combinational. Valid passes forward and ready passes backward unchanged.

Top module: `hv_prefix_adder`

## Requirements
- R1: For every legal parameter set, the outputs match a behavioural addition. Legal means `VALENCY` of 2 or more and `BLOCK` dividing `WIDTH`. The sets checked include valency 2, 3 and 4, a single block and several blocks.
- R2: With `eac_mode`=0, `{cout, sum}` equals `a + b + cin` taken to `WIDTH+1` bits.
- R3: With `eac_mode`=1, let c be the carry out of `a + b`. Then `cout` equals c and `sum` equals `(a + b + c) mod 2^WIDTH`.
- R4: `grp_prop` is 1 exactly when every bit position propagates, meaning `a ^ b` is all ones. This holds in both modes.
- R5: `neg_zero` is 1 exactly when `eac_mode`=1 and `grp_prop`=1. In that case `sum` is all ones and `cout` is 0.
- R6: In end-around mode the `cin` pin has no effect on any output.
- R7: With `PIPE`=0, the results follow the operands in the same cycle, `out_valid` equals `in_valid`, and `in_ready` equals `out_ready`.
- R8: With `PIPE`=1, a pair accepted at a clock edge (`in_valid` and `in_ready` both high) appears on the outputs after that edge with `out_valid`=1.
- R9: With `PIPE`=1, while `out_valid`=1 and `out_ready`=0, the outputs stay stable and `in_ready` is 0. While `out_ready`=1, `in_ready` is 1.
- R10: With `PIPE`=1, `out_valid` is 0 during and directly after an active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry-in, used in normal mode only |
| eac_mode | input | 1 | 1 selects end-around-carry addition |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result |
| sum | output | WIDTH | Sum word |
| cout | output | 1 | Carry-out, or the end-around carry in EAC mode |
| grp_prop | output | 1 | Every bit of the word propagates |
| neg_zero | output | 1 | EAC result is the all-ones negative zero |

## Verification
Random operands almost never propagate through the full word. This means the all-propagate case, the negative-zero case, and the end-around carry that crosses block boundaries would stay unexercised. The stimulus therefore mixes in directed patterns:

- complementary operands, in both modes;
- all-ones operands;
- operands that carry out of exactly one block;
- random pairs in which b is forced to the complement of a in most bits.

The same operands drive three instances with different valency and block spacing. A back-pressure sequence stalls the output register while a second pair waits at the input.

// File: rtl/hvpa_pkg.sv
package hvpa_pkg;
  // number of radix-v prefix levels needed to span n positions
  function automatic int levels_for(input int n, input int v);
    int lv;
    longint span;
    lv = 0;
    span = 1;
    while (span < longint'(n)) begin
      span = span * longint'(v);
      lv++;
    end
    return lv;
  endfunction
endpackage

// File: rtl/hvpa_tree.sv
// Inclusive radix-V prefix network: output i is the group (G,P) of positions [i:0].
module hvpa_tree #(
  parameter int N = 8,
  parameter int V = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  output logic [N-1:0] gen_o,
  output logic [N-1:0] prop_o
);
  import hvpa_pkg::*;
  localparam int LV = levels_for(N, V);

  always_comb begin
    logic [N-1:0] gc, pc, gn, pn;
    int span;
    gc = gen_i;
    pc = prop_i;
    span = 1;
    for (int l = 0; l < LV; l++) begin
      gn = gc;
      pn = pc;
      // each node is one valency-V cell: merge V neighbouring groups, high to low
      for (int i = 0; i < N; i++) begin
        for (int j = 1; j < V; j++) begin
          int src;
          src = i - j * span;
          if (src >= 0) begin
            gn[i] = gn[i] | (pn[i] & gc[src]);
            pn[i] = pn[i] & pc[src];
          end
        end
      end
      gc = gn;
      pc = pn;
      span = span * V;
    end
    gen_o  = gc;
    prop_o = pc;
  end
endmodule

// File: rtl/hvpa_core.sv
// Blocked prefix carry logic: local sub-tree per block, global tree over blocks.
module hvpa_core #(
  parameter int WIDTH   = 32,
  parameter int VALENCY = 4,
  parameter int BLOCK   = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             eac,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             p_all
);
  localparam int NB = WIDTH / BLOCK;

  if ((WIDTH % BLOCK) != 0 || VALENCY < 2 || BLOCK < 1) begin : g_bad_cfg
    $error("hvpa_core: BLOCK must divide WIDTH and VALENCY must be at least 2");
  end

  logic [WIDTH-1:0] bit_g, bit_p, loc_g, loc_p, carry;
  logic [NB-1:0]    blk_g, blk_p, pre_g, pre_p, blk_cin;
  logic             g_all, cin_eff;

  assign bit_g = a & b;
  assign bit_p = a ^ b;

  for (genvar k = 0; k < NB; k++) begin : g_blk
    hvpa_tree #(.N(BLOCK), .V(VALENCY)) u_local (
      .gen_i (bit_g[k*BLOCK +: BLOCK]),
      .prop_i(bit_p[k*BLOCK +: BLOCK]),
      .gen_o (loc_g[k*BLOCK +: BLOCK]),
      .prop_o(loc_p[k*BLOCK +: BLOCK])
    );
    assign blk_g[k] = loc_g[k*BLOCK + BLOCK - 1];
    assign blk_p[k] = loc_p[k*BLOCK + BLOCK - 1];
  end

  hvpa_tree #(.N(NB), .V(VALENCY)) u_global (
    .gen_i (blk_g),
    .prop_i(blk_p),
    .gen_o (pre_g),
    .prop_o(pre_p)
  );

  assign g_all   = pre_g[NB-1];
  assign p_all   = pre_p[NB-1];
  // end-around: the whole-word generate is the carry that re-enters at bit 0
  assign cin_eff = eac ? g_all : cin;

  for (genvar k = 0; k < NB; k++) begin : g_bcin
    if (k == 0) begin : g_first
      assign blk_cin[k] = cin_eff;
    end else begin : g_rest
      assign blk_cin[k] = pre_g[k-1] | (pre_p[k-1] & cin_eff);
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if ((i % BLOCK) == 0) begin : g_edge
      assign carry[i] = blk_cin[i / BLOCK];
    end else begin : g_inner
      assign carry[i] = loc_g[i-1] | (loc_p[i-1] & blk_cin[i / BLOCK]);
    end
  end

  assign sum  = bit_p ^ carry;
  assign cout = g_all | (p_all & cin_eff);
endmodule

// File: rtl/hvpa_outreg.sv
// Optional single-entry output register with valid/ready.
module hvpa_outreg #(
  parameter int DW   = 35,
  parameter bit PIPE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  if (PIPE) begin : g_reg
    logic          vld_q;
    logic [DW-1:0] dat_q;

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign out_data  = dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) dat_q <= in_data;
      end
    end

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/hv_prefix_adder.sv
module hv_prefix_adder #(
  parameter int WIDTH   = 32,
  parameter int VALENCY = 4,
  parameter int BLOCK   = 8,
  parameter bit PIPE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             eac_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             grp_prop,
  output logic             neg_zero
);
  localparam int DW = WIDTH + 3;

  logic [WIDTH-1:0] c_sum;
  logic             c_cout, c_pall, c_nz;
  logic [DW-1:0]    c_pack, q_pack;

  hvpa_core #(.WIDTH(WIDTH), .VALENCY(VALENCY), .BLOCK(BLOCK)) u_core (
    .a    (a),
    .b    (b),
    .cin  (cin),
    .eac  (eac_mode),
    .sum  (c_sum),
    .cout (c_cout),
    .p_all(c_pall)
  );

  assign c_nz   = eac_mode & c_pall;
  assign c_pack = {c_nz, c_pall, c_cout, c_sum};

  hvpa_outreg #(.DW(DW), .PIPE(PIPE)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (c_pack),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (q_pack)
  );

  assign {neg_zero, grp_prop, cout, sum} = q_pack;

  // behavioural reference used only by the properties below
  logic [WIDTH:0]   chk_raw;
  logic [WIDTH-1:0] chk_wrap;
  assign chk_raw  = {1'b0, a} + {1'b0, b};
  assign chk_wrap = chk_raw[WIDTH-1:0] + {{(WIDTH-1){1'b0}}, chk_raw[WIDTH]};

  assert_normal_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !eac_mode) |-> ({c_cout, c_sum} == chk_raw + {{WIDTH{1'b0}}, cin}));
  assert_eac_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eac_mode) |-> (c_sum == chk_wrap && c_cout == chk_raw[WIDTH]));
  assert_grp_prop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (c_pall == ((a ^ b) == {WIDTH{1'b1}})));
  assert_neg_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && c_nz) |-> (c_sum == {WIDTH{1'b1}} && !c_cout));
endmodule

// File: tb/hv_prefix_adder_tb.sv
`timescale 1ns/1ps
module hv_prefix_adder_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, cin = 1'b0, mode = 1'b0;
  logic [W-1:0] a = '0, b = '0;

  always #10 clk = ~clk;

  logic          ir4, ov4, co4, pa4, nz4;
  logic [W-1:0]  s4;
  logic          ir2, ov2, co2, pa2, nz2;
  logic [W-1:0]  s2;
  logic          ir3, ov3, co3, pa3, nz3;
  logic [W-1:0]  s3;

  hv_prefix_adder #(.WIDTH(W), .VALENCY(4), .BLOCK(8), .PIPE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir4), .a(a), .b(b),
    .cin(cin), .eac_mode(mode), .out_valid(ov4), .out_ready(out_ready),
    .sum(s4), .cout(co4), .grp_prop(pa4), .neg_zero(nz4));
  hv_prefix_adder #(.WIDTH(W), .VALENCY(2), .BLOCK(32), .PIPE(1'b0)) u_dut_v2 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir2), .a(a), .b(b),
    .cin(cin), .eac_mode(mode), .out_valid(ov2), .out_ready(out_ready),
    .sum(s2), .cout(co2), .grp_prop(pa2), .neg_zero(nz2));
  hv_prefix_adder #(.WIDTH(W), .VALENCY(3), .BLOCK(16), .PIPE(1'b0)) u_dut_v3 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(ir3), .a(a), .b(b),
    .cin(cin), .eac_mode(mode), .out_valid(ov3), .out_ready(out_ready),
    .sum(s3), .cout(co3), .grp_prop(pa3), .neg_zero(nz3));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [W+2:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic ci, input logic m);
    logic [W:0] raw;
    logic [W-1:0] s;
    logic pa;
    pa = ((x ^ y) == {W{1'b1}});
    raw = {1'b0, x} + {1'b0, y};
    if (m) s = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    else begin
      raw = raw + {{W{1'b0}}, ci};
      s = raw[W-1:0];
    end
    return {m & pa, pa, raw[W], s};
  endfunction

  task automatic chk(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one transaction: combinational instances checked in-cycle, registered one a cycle later
  task automatic do_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci, input logic m);
    logic [W+2:0] e;
    e = ref_add(x, y, ci, m);
    @(negedge clk);
    a = x; b = y; cin = ci; mode = m; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk(m ? "R1/R3/R4/R5/R6 v2" : "R1/R2/R4/R5 v2", {nz2, pa2, co2, s2}, e);
    chk(m ? "R1/R3/R4/R5/R6 v3" : "R1/R2/R4/R5 v3", {nz3, pa3, co3, s3}, e);
    chk("R7 handshake", {33'd0, ov2, ir3}, {33'd0, in_valid, out_ready});
    @(negedge clk);
    chk("R1/R8 v4 result", {nz4, pa4, co4, s4}, e);
    chk("R8 valid", {34'd0, ov4}, 35'd1);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y, msk;
    logic [W+2:0] e1, e2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R10 reset", {34'd0, ov4}, 35'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", {34'd0, ov4}, 35'd0);

    // directed corners
    do_op('0, '0, 1'b0, 1'b0);
    do_op({W{1'b1}}, 32'd1, 1'b0, 1'b0);
    do_op({W{1'b1}}, '0, 1'b1, 1'b0);
    do_op(32'h0F0F_F0F0, 32'hF0F0_0F0F, 1'b1, 1'b0);
    do_op(32'h0F0F_F0F0, 32'hF0F0_0F0F, 1'b0, 1'b1);
    do_op(32'h0F0F_F0F0, 32'hF0F0_0F0F, 1'b1, 1'b1);
    do_op({W{1'b1}}, {W{1'b1}}, 1'b0, 1'b1);
    do_op(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b1);
    do_op(32'h0000_00FF, 32'h0000_0001, 1'b0, 1'b1);
    do_op(32'h7FFF_FFFF, 32'h8000_0001, 1'b1, 1'b1);
    do_op(32'hFFFF_FF00, 32'h0000_0100, 1'b0, 1'b1);

    // R6: same operands, both cin values, end-around mode
    @(negedge clk);
    a = 32'h1234_5678; b = 32'hF000_0001; mode = 1'b1; cin = 1'b0; #1;
    e1 = {nz3, pa3, co3, s3};
    cin = 1'b1; #1;
    e2 = {nz3, pa3, co3, s3};
    chk("R6 cin ignored", e2, e1);

    // constrained random, with near-complement pairs to reach long propagation
    for (int n = 0; n < 400; n++) begin
      x = $urandom;
      msk = (n % 3 == 0) ? ($urandom & $urandom & $urandom) : $urandom;
      y = (n % 2 == 0) ? (~x ^ msk) : $urandom;
      if (n % 7 == 0) y = ~x;
      do_op(x, y, 1'(($urandom >> 3) & 1), 1'(($urandom >> 5) & 1));
    end

    // R9: back-pressure on the registered instance
    @(negedge clk);
    e1 = ref_add(32'hAAAA_0001, 32'h5555_FFFF, 1'b1, 1'b0);
    a = 32'hAAAA_0001; b = 32'h5555_FFFF; cin = 1'b1; mode = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk("R9 first held", {nz4, pa4, co4, s4}, e1);
    chk("R9 stall ready", {33'd0, ov4, ir4}, {33'd0, 1'b1, 1'b0});
    e2 = ref_add(32'h0000_0003, 32'h0000_0004, 1'b0, 1'b1);
    a = 32'h0000_0003; b = 32'h0000_0004; cin = 1'b0; mode = 1'b1;
    @(negedge clk);
    chk("R9 still held", {nz4, pa4, co4, s4}, e1);
    out_ready = 1'b1; #1;
    chk("R9 ready returns", {34'd0, ir4}, 35'd1);
    @(negedge clk);
    chk("R9 second taken", {nz4, pa4, co4, s4}, e2);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 drained", {34'd0, ov4}, 35'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule